// File: doc/BRIEF.md
# QoS Identifier Control Register

This block holds the two quality-of-service tags that a hart attaches to every request it sends into shared resources: a control tag, which selects the allocation policy (cache ways, bandwidth share), and a monitor tag, which selects the counters that account for the traffic. Both tags are driven to the memory system as steady sideband outputs. They apply equally to every privilege level the hart runs at.

Software reaches the tags through a single supervisor-level control register at address 0x181. The block sees a one-cycle request from the CSR stage: valid, address, write flag, write data, current mode, the guest flag and a machine-level enable bit. In that same cycle it answers with read data and at most one exception flag. A granted write only keeps the bits that fit the implemented tag widths. It takes effect at the next clock edge, so a later read returns the values that were actually kept.

The mode code is 2'b00 for user, 2'b01 for supervisor, 2'b11 for machine, and 2'b10 is reserved. In the register image, the control tag sits in bits 11:0 and the monitor tag sits in bits 27:16.

Top module: `qos_tag_csr`

## Requirements
- R1: While reset is asserted, and after it is released, both tag outputs read zero until a granted write changes them.
- R2: A granted write to address 0x181 loads write-data bits 11:0 into the control tag and bits 27:16 into the monitor tag at the next rising clock edge.
- R3: Write-data bits outside 11:0 and 27:16 are discarded. In read data, every bit outside those two fields reads as zero.
- R4: An access at 0x181 with mode code 2'b00 or 2'b10 raises the illegal-instruction flag.
- R5: When the machine enable bit is 0, an access at 0x181 from supervisor mode raises the illegal-instruction flag. From machine mode it is not blocked.
- R6: When the guest flag is 1 and no illegal-instruction condition applies, an access raises the virtual-instruction flag. Illegal-instruction takes precedence, and the two flags are never high together.
- R7: An access that raises either flag leaves both tags unchanged, and its read data is zero.
- R8: An access to any address other than 0x181 raises no flag, returns zero read data and leaves both tags unchanged.
- R9: The tag outputs always equal the stored register fields, whatever the mode code of the current request.
- R10: A granted read (write flag 0) returns the stored image in the same cycle and does not change the tags.
- R11: When valid is low, the other request inputs have no effect on flags, read data or tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | CSR address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | XLEN (64) | Write data |
| req_priv | input | 2 | Current mode code |
| req_virt | input | 1 | Guest (virtualized) flag |
| req_sten | input | 1 | Machine-level enable for this register |
| rsp_rdata | output | XLEN (64) | Read data, same cycle |
| rsp_ill | output | 1 | Illegal-instruction exception |
| rsp_virt_ill | output | 1 | Virtual-instruction exception |
| qos_ctl_id | output | 12 | Resource-control tag to the memory system |
| qos_mon_id | output | 12 | Monitoring tag to the memory system |

## Verification
Two exception causes can hit the same access. A supervisor request with the guest flag set and the machine enable bit clear qualifies for both virtual-instruction and illegal-instruction. A user-mode request with the guest flag set does the same. The stimulus table drives both combinations, and each is judged by requiring only the illegal-instruction flag, zero read data and unchanged tags on the following cycle. A third case is a write that is granted in the same cycle it is read back: the read data must show the old image, and the new image must show only after the edge.

// File: rtl/qos_tag_pkg.sv
package qos_tag_pkg;

  localparam int unsigned CSR_ADDR_W = 12;

  typedef enum logic [1:0] {
    MODE_USER  = 2'b00,
    MODE_SUPER = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_MACH  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_GRANT = 2'b01,
    ACC_ILL   = 2'b10,
    ACC_VILL  = 2'b11
  } acc_e;

endpackage

// File: rtl/qos_tag_access_gate.sv
module qos_tag_access_gate
  import qos_tag_pkg::*;
#(
  parameter logic [CSR_ADDR_W-1:0] CSR_ADDR    = 12'h181,
  parameter bit                    HAS_FEATURE = 1'b1,
  parameter bit                    HAS_STATEEN = 1'b1
) (
  input  logic                  valid_i,
  input  logic [CSR_ADDR_W-1:0] addr_i,
  input  logic [1:0]            mode_i,
  input  logic                  virt_i,
  input  logic                  sten_i,
  output acc_e                  acc_o
);

  logic hit;
  logic feat_ok;
  logic mode_ok;
  logic sten_ok;
  logic ill_cond;

  assign hit     = valid_i && (addr_i == CSR_ADDR);
  assign mode_ok = (mode_i == MODE_SUPER) || (mode_i == MODE_MACH);

  generate
    if (HAS_FEATURE) begin : g_feat
      assign feat_ok = 1'b1;
    end else begin : g_nofeat
      assign feat_ok = 1'b0;
    end
  endgenerate

  generate
    if (HAS_STATEEN) begin : g_sten
      assign sten_ok = (mode_i == MODE_MACH) || sten_i;
    end else begin : g_nosten
      logic unused_sten;
      assign unused_sten = sten_i;
      assign sten_ok     = 1'b1;
    end
  endgenerate

  assign ill_cond = !feat_ok || !mode_ok || !sten_ok;

  always_comb begin
    acc_o = ACC_NONE;
    if (hit) begin
      if (ill_cond) begin
        acc_o = ACC_ILL;
      end else if (virt_i) begin
        acc_o = ACC_VILL;
      end else begin
        acc_o = ACC_GRANT;
      end
    end
  end

endmodule

// File: rtl/qos_tag_legalizer.sv
module qos_tag_legalizer #(
  parameter int unsigned XLEN    = 64,
  parameter int unsigned CTL_W   = 12,
  parameter int unsigned MON_W   = 12,
  parameter int unsigned CTL_LSB = 0,
  parameter int unsigned MON_LSB = 16
) (
  input  logic [XLEN-1:0]  wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic [MON_W-1:0] mon_o,
  input  logic [CTL_W-1:0] ctl_q_i,
  input  logic [MON_W-1:0] mon_q_i,
  output logic [XLEN-1:0]  image_o
);

  localparam logic [XLEN-1:0] CTL_MASK = {{(XLEN-CTL_W){1'b0}}, {CTL_W{1'b1}}} << CTL_LSB;
  localparam logic [XLEN-1:0] MON_MASK = {{(XLEN-MON_W){1'b0}}, {MON_W{1'b1}}} << MON_LSB;
  localparam logic [XLEN-1:0] KEEP     = CTL_MASK | MON_MASK;

  logic unused_bits;

  assign ctl_o       = wdata_i[CTL_LSB +: CTL_W];
  assign mon_o       = wdata_i[MON_LSB +: MON_W];
  assign unused_bits = ^(wdata_i & ~KEEP);

  always_comb begin
    image_o                        = '0;
    image_o[CTL_LSB +: CTL_W]      = ctl_q_i;
    image_o[MON_LSB +: MON_W]      = mon_q_i;
  end

endmodule

// File: rtl/qos_tag_store.sv
module qos_tag_store #(
  parameter int unsigned CTL_W = 12,
  parameter int unsigned MON_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CTL_W-1:0] ctl_d_i,
  input  logic [MON_W-1:0] mon_d_i,
  output logic [CTL_W-1:0] ctl_q_o,
  output logic [MON_W-1:0] mon_q_o
);

  logic [CTL_W-1:0] ctl_nxt;
  logic [MON_W-1:0] mon_nxt;

  always_comb begin
    ctl_nxt = ctl_q_o;
    mon_nxt = mon_q_o;
    if (we_i) begin
      ctl_nxt = ctl_d_i;
      mon_nxt = mon_d_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q_o <= '0;
      mon_q_o <= '0;
    end else if (we_i) begin
      ctl_q_o <= ctl_nxt;
      mon_q_o <= mon_nxt;
    end
  end

endmodule

// File: rtl/qos_tag_csr.sv
module qos_tag_csr
  import qos_tag_pkg::*;
#(
  parameter int unsigned           XLEN        = 64,
  parameter logic [CSR_ADDR_W-1:0] CSR_ADDR    = 12'h181,
  parameter int unsigned           CTL_W       = 12,
  parameter int unsigned           MON_W       = 12,
  parameter int unsigned           CTL_LSB     = 0,
  parameter int unsigned           MON_LSB     = 16,
  parameter bit                    HAS_FEATURE = 1'b1,
  parameter bit                    HAS_STATEEN = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [CSR_ADDR_W-1:0] req_addr,
  input  logic                  req_write,
  input  logic [XLEN-1:0]       req_wdata,
  input  logic [1:0]            req_priv,
  input  logic                  req_virt,
  input  logic                  req_sten,
  output logic [XLEN-1:0]       rsp_rdata,
  output logic                  rsp_ill,
  output logic                  rsp_virt_ill,
  output logic [CTL_W-1:0]      qos_ctl_id,
  output logic [MON_W-1:0]      qos_mon_id
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  acc_e             acc;
  logic             wr_en;
  logic [CTL_W-1:0] ctl_legal;
  logic [MON_W-1:0] mon_legal;
  logic [XLEN-1:0]  image;

  qos_tag_access_gate #(
    .CSR_ADDR    (CSR_ADDR),
    .HAS_FEATURE (HAS_FEATURE),
    .HAS_STATEEN (HAS_STATEEN)
  ) u_gate (
    .valid_i (req_valid),
    .addr_i  (req_addr),
    .mode_i  (req_priv),
    .virt_i  (req_virt),
    .sten_i  (req_sten),
    .acc_o   (acc)
  );

  qos_tag_legalizer #(
    .XLEN    (XLEN),
    .CTL_W   (CTL_W),
    .MON_W   (MON_W),
    .CTL_LSB (CTL_LSB),
    .MON_LSB (MON_LSB)
  ) u_legal (
    .wdata_i (req_wdata),
    .ctl_o   (ctl_legal),
    .mon_o   (mon_legal),
    .ctl_q_i (qos_ctl_id),
    .mon_q_i (qos_mon_id),
    .image_o (image)
  );

  assign wr_en = (acc == ACC_GRANT) && req_write && rst_q_n;

  qos_tag_store #(
    .CTL_W (CTL_W),
    .MON_W (MON_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .we_i    (wr_en),
    .ctl_d_i (ctl_legal),
    .mon_d_i (mon_legal),
    .ctl_q_o (qos_ctl_id),
    .mon_q_o (qos_mon_id)
  );

  always_comb begin
    rsp_rdata    = '0;
    rsp_ill      = 1'b0;
    rsp_virt_ill = 1'b0;
    unique case (acc)
      ACC_GRANT: rsp_rdata    = image;
      ACC_ILL:   rsp_ill      = 1'b1;
      ACC_VILL:  rsp_virt_ill = 1'b1;
      default:   rsp_rdata    = '0;
    endcase
  end

endmodule

// File: rtl/qos_tag_csr_chk.sv
module qos_tag_csr_chk #(
  parameter int unsigned XLEN        = 64,
  parameter logic [11:0] CSR_ADDR    = 12'h181,
  parameter int unsigned CTL_W       = 12,
  parameter int unsigned MON_W       = 12,
  parameter int unsigned CTL_LSB     = 0,
  parameter int unsigned MON_LSB     = 16,
  parameter bit          HAS_STATEEN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_q_n,
  input logic             req_valid,
  input logic [11:0]      req_addr,
  input logic             req_write,
  input logic [XLEN-1:0]  req_wdata,
  input logic [1:0]       req_priv,
  input logic             req_virt,
  input logic             req_sten,
  input logic [XLEN-1:0]  rsp_rdata,
  input logic             rsp_ill,
  input logic             rsp_virt_ill,
  input logic [CTL_W-1:0] qos_ctl_id,
  input logic [MON_W-1:0] qos_mon_id
);

  localparam logic [XLEN-1:0] KEEP =
    ({{(XLEN-CTL_W){1'b0}}, {CTL_W{1'b1}}} << CTL_LSB) |
    ({{(XLEN-MON_W){1'b0}}, {MON_W{1'b1}}} << MON_LSB);

  logic hit;
  assign hit = req_valid && (req_addr == CSR_ADDR);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (qos_ctl_id == '0 && qos_mon_id == '0)
        else $error("reset did not clear tags");
    end
  end

  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hit && req_write && !rsp_ill && !rsp_virt_ill) |=>
      (qos_ctl_id == $past(req_wdata[CTL_LSB +: CTL_W]) &&
       qos_mon_id == $past(req_wdata[MON_LSB +: MON_W])));

  p_rdata_mask_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_rdata & ~KEEP) == '0);

  p_low_mode_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hit && (req_priv == 2'b00 || req_priv == 2'b10)) |-> rsp_ill);

  p_sten_block_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (HAS_STATEEN && hit && req_priv == 2'b01 && !req_sten) |-> rsp_ill);

  p_flags_onehot_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({rsp_ill, rsp_virt_ill}));

  p_virt_raise_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hit && req_priv == 2'b01 && req_sten && req_virt) |-> rsp_virt_ill);

  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rsp_ill || rsp_virt_ill) |=> ($stable(qos_ctl_id) && $stable(qos_mon_id)));

  p_other_addr_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_addr != CSR_ADDR) |-> (!rsp_ill && !rsp_virt_ill && rsp_rdata == '0));

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (hit && !req_write) |=> ($stable(qos_ctl_id) && $stable(qos_mon_id)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |-> (!rsp_ill && !rsp_virt_ill && rsp_rdata == '0));

endmodule

bind qos_tag_csr qos_tag_csr_chk #(
  .XLEN        (XLEN),
  .CSR_ADDR    (CSR_ADDR),
  .CTL_W       (CTL_W),
  .MON_W       (MON_W),
  .CTL_LSB     (CTL_LSB),
  .MON_LSB     (MON_LSB),
  .HAS_STATEEN (HAS_STATEEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_q_n      (rst_q_n),
  .req_valid    (req_valid),
  .req_addr     (req_addr),
  .req_write    (req_write),
  .req_wdata    (req_wdata),
  .req_priv     (req_priv),
  .req_virt     (req_virt),
  .req_sten     (req_sten),
  .rsp_rdata    (rsp_rdata),
  .rsp_ill      (rsp_ill),
  .rsp_virt_ill (rsp_virt_ill),
  .qos_ctl_id   (qos_ctl_id),
  .qos_mon_id   (qos_mon_id)
);

// File: tb/qos_tag_csr_tb.sv
`timescale 1ns/1ps
module qos_tag_csr_tb;

  localparam logic [63:0] KEEP = 64'h0000_0000_0FFF_0FFF;

  typedef struct packed {
    logic        v;
    logic [1:0]  md;
    logic        vt;
    logic        st;
    logic [11:0] ad;
    logic        wr;
    logic [63:0] wd;
    logic        e_ill;
    logic        e_vill;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TABLE [NV] = '{
    '{1'b1, 2'd1, 1'b0, 1'b1, 12'h181, 1'b1, 64'hFFFF_FFFF_FABC_F123, 1'b0, 1'b0}, // R2 R3
    '{1'b1, 2'd1, 1'b0, 1'b1, 12'h181, 1'b0, 64'h0,                   1'b0, 1'b0}, // R10
    '{1'b1, 2'd0, 1'b0, 1'b1, 12'h181, 1'b1, 64'h0000_0000_0555_0555, 1'b1, 1'b0}, // R4
    '{1'b1, 2'd2, 1'b0, 1'b1, 12'h181, 1'b1, 64'h0000_0000_0555_0555, 1'b1, 1'b0}, // R4
    '{1'b1, 2'd1, 1'b0, 1'b0, 12'h181, 1'b1, 64'h0000_0000_0666_0666, 1'b1, 1'b0}, // R5
    '{1'b1, 2'd3, 1'b0, 1'b0, 12'h181, 1'b1, 64'h0000_0000_0777_0001, 1'b0, 1'b0}, // R5
    '{1'b1, 2'd1, 1'b1, 1'b1, 12'h181, 1'b1, 64'h0000_0000_0888_0888, 1'b0, 1'b1}, // R6
    '{1'b1, 2'd1, 1'b1, 1'b0, 12'h181, 1'b1, 64'h0000_0000_0999_0999, 1'b1, 1'b0}, // R6 precedence
    '{1'b1, 2'd0, 1'b1, 1'b1, 12'h181, 1'b0, 64'h0,                   1'b1, 1'b0}, // R6 precedence
    '{1'b1, 2'd1, 1'b0, 1'b1, 12'h180, 1'b1, 64'h0000_0000_0AAA_0AAA, 1'b0, 1'b0}, // R8
    '{1'b0, 2'd1, 1'b0, 1'b1, 12'h181, 1'b1, 64'h0000_0000_0BBB_0BBB, 1'b0, 1'b0}, // R11
    '{1'b1, 2'd3, 1'b0, 1'b1, 12'h181, 1'b1, 64'h0,                   1'b0, 1'b0}, // R2 clear
    '{1'b1, 2'd1, 1'b0, 1'b1, 12'h181, 1'b1, 64'h8000_0000_0FFF_0FFF, 1'b0, 1'b0}, // R2 R3 max
    '{1'b1, 2'd3, 1'b0, 1'b1, 12'h181, 1'b0, 64'h0,                   1'b0, 1'b0}  // R9 R10
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [11:0] req_addr;
  logic        req_write;
  logic [63:0] req_wdata;
  logic [1:0]  req_priv;
  logic        req_virt;
  logic        req_sten;
  logic [63:0] rsp_rdata;
  logic        rsp_ill;
  logic        rsp_virt_ill;
  logic [11:0] qos_ctl_id;
  logic [11:0] qos_mon_id;

  int checks;
  int failures;
  bit done;

  logic [63:0] model;

  qos_tag_csr u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .req_wdata    (req_wdata),
    .req_priv     (req_priv),
    .req_virt     (req_virt),
    .req_sten     (req_sten),
    .rsp_rdata    (rsp_rdata),
    .rsp_ill      (rsp_ill),
    .rsp_virt_ill (rsp_virt_ill),
    .qos_ctl_id   (qos_ctl_id),
    .qos_mon_id   (qos_mon_id)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
    req_priv = 2'd1; req_virt = 1'b0; req_sten = 1'b1;
  endtask

  task automatic check_ids(input string req);
    check(req, {40'h0, qos_mon_id, 4'h0, qos_ctl_id}, model & KEEP);
  endtask

  task automatic apply(input vec_t t, input int idx);
    logic ok;
    @(negedge clk);
    req_valid = t.v; req_priv = t.md; req_virt = t.vt; req_sten = t.st;
    req_addr = t.ad; req_write = t.wr; req_wdata = t.wd;
    ok = t.v && (t.ad == 12'h181) && !t.e_ill && !t.e_vill;
    #1;
    check($sformatf("R4/R5/R6 ill vec%0d", idx), {63'h0, rsp_ill}, {63'h0, t.e_ill});
    check($sformatf("R6 vill vec%0d", idx), {63'h0, rsp_virt_ill}, {63'h0, t.e_vill});
    check($sformatf("R3/R7/R8/R10/R11 rdata vec%0d", idx), rsp_rdata, ok ? (model & KEEP) : 64'h0);
    @(posedge clk);
    if (ok && t.wr) model = t.wd & KEEP;
    @(negedge clk);
    idle();
    #1;
    check_ids($sformatf("R2/R7/R9 tags vec%0d", idx));
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0; model = '0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_ids("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_ids("R1 after release");

    for (int i = 0; i < NV; i++) apply(TABLE[i], i);

    // granted write read in its own cycle shows the old image: R10
    @(negedge clk);
    req_valid = 1'b1; req_addr = 12'h181; req_write = 1'b1; req_priv = 2'd1;
    req_wdata = 64'h0000_0000_0123_0456;
    #1;
    check("R10 old image on write cycle", rsp_rdata, model & KEEP);
    @(posedge clk);
    model = 64'h0000_0000_0123_0456;
    @(negedge clk);
    idle();
    // mode change alone does not move the tags: R9
    req_priv = 2'd0;
    #1;
    check_ids("R9 tags with user mode");

    // asynchronous reset clears tags: R1
    rst_n = 1'b0;
    #1;
    model = '0;
    check_ids("R1 async clear");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_ids("R1 hold after second reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule